// File: doc/BRIEF.md
# Cut-Through Readout Fragment Formatter

The block wraps the data words of one event into a 32-bit readout fragment without ever holding the whole event. A one-cycle start pulse brings in the event descriptor: format version, source code, region, bunch count, buffer number and the latency already recorded upstream. On that same cycle the block samples a free-running latency counter. It then emits a header word and a latency stamp word. After those it passes each payload word from its input stream to its output stream in the cycle the word arrives. When the word flagged as last has been accepted, it appends a trailer carrying the payload word count and the error flags.

The payload length is only known at the end, so the count lives in the trailer and not in the header. This lets the first payload word leave the block a couple of cycles after the start pulse, however long the event is. A single control bit on the output separates framing words from payload.

Both streams use valid/ready. A word moves when valid and ready are high in the same cycle. Valid, once raised, holds with stable data until accepted. The output ready is the only throttle: while it is low, no framing word advances and no payload word is accepted at the input. The start pulse, descriptor, latency counter and error inputs are plain level signals sampled on the clock edge.

Top module: `frag_stream_fmt`

## Requirements
- R1: While reset is held and right after it, out_valid and in_ready are low.
- R2: Each fragment leaves in this order: one header word, one stamp word, the payload words in arrival order, one trailer word.
- R3: Header word layout: bits 31:24 version, 23:20 source, 19:16 region, 15:8 bunch count, 7:0 buffer number, all sampled with the start pulse.
- R4: Stamp word: bits 31:16 the upstream latency input, and bits 15:0 the latency counter, both sampled with the start pulse. The counter value is clamped to 0xFFFF when it exceeds that value.
- R5: Trailer word: bits 31:16 the number of payload words in the fragment. Bits 14:0 are the error input sampled with the last payload word. Bit 15 is the overlap flag of R9.
- R6: out_ctl is 1 on header, stamp and trailer words and 0 on payload words.
- R7: During the payload phase, in_ready equals out_ready, and an offered input word shows on out_data with out_valid in the same cycle.
- R8: While out_ready is low, a pending output word keeps out_valid high and out_data unchanged, and no word is lost or reordered.
- R9: A start pulse that arrives during the header, stamp or payload phase is dropped, and its descriptor emits nothing. This includes a pulse in the same cycle as the last payload word. The dropped pulse sets trailer bit 15 of the current fragment.
- R10: A start pulse that arrives while the trailer waits for out_ready is held. The next header follows in the cycle after the trailer is accepted.
- R11: The trailer count saturates at 0xFFFF.
- R12: in_ready is low outside the payload phase, including while a header is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Start-of-event pulse |
| ev_ver | input | 8 | Format version |
| ev_src | input | 4 | Source code |
| ev_region | input | 4 | Region identifier |
| ev_bunch | input | 8 | Bunch count |
| ev_buf | input | 8 | Buffer number |
| prev_lat | input | 16 | Latency recorded upstream |
| lat_now | input | LAT_W | Free-running latency counter |
| err_in | input | 15 | Error flags, sampled with the last word |
| in_valid | input | 1 | Payload word offered |
| in_ready | output | 1 | Payload word accepted |
| in_data | input | 32 | Payload word |
| in_last | input | 1 | Marks the final payload word |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Output word accepted |
| out_data | output | 32 | Output word |
| out_ctl | output | 1 | High on framing words |

## Verification
A corrupted phase register shows at once at the ports. Possible symptoms are a framing word with out_ctl low, in_ready high while a header is pending, or a trailer missing one cycle after the last handshake. A word counter that is off, or an error flag that is lost, stays hidden until the trailer word. That word is one accepted handshake after the last payload word. A descriptor overwritten by a dropped or held start pulse shows in the next header or stamp word. The bench compares every output word with a model built from the requirements, across word counts, ready patterns and input gaps.

// File: rtl/frag_pkg.sv
package frag_pkg;

  localparam int WORD_W = 32;
  localparam int SIZE_W = 16;
  localparam int ERR_W  = 15;
  localparam int STMP_W = 16;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_HDR   = 3'd1,
    PH_STAMP = 3'd2,
    PH_DATA  = 3'd3,
    PH_TRL   = 3'd4
  } phase_t;

  typedef struct packed {
    logic [7:0]        ver;
    logic [3:0]        src;
    logic [3:0]        region;
    logic [7:0]        bunch;
    logic [7:0]        bufn;
    logic [STMP_W-1:0] up_lat;
    logic [STMP_W-1:0] here_lat;
  } desc_t;

endpackage

// File: rtl/frag_desc_cap.sv
module frag_desc_cap
  import frag_pkg::*;
#(
  parameter int LAT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       ev_ver,
  input  logic [3:0]       ev_src,
  input  logic [3:0]       ev_region,
  input  logic [7:0]       ev_bunch,
  input  logic [7:0]       ev_buf,
  input  logic [15:0]      prev_lat,
  input  logic [LAT_W-1:0] lat_now,
  input  logic             load_new,
  input  logic             load_held,
  input  logic             hold_new,
  output desc_t            cur,
  output logic             held_vld
);

  logic [STMP_W-1:0] lat_clamped;
  desc_t             fresh;
  desc_t             held;

  generate
    if (LAT_W > STMP_W) begin : g_clamp
      assign lat_clamped = (|lat_now[LAT_W-1:STMP_W]) ? {STMP_W{1'b1}}
                                                       : lat_now[STMP_W-1:0];
    end else if (LAT_W == STMP_W) begin : g_same
      assign lat_clamped = lat_now;
    end else begin : g_pad
      assign lat_clamped = {{(STMP_W-LAT_W){1'b0}}, lat_now};
    end
  endgenerate

  always_comb begin
    fresh.ver      = ev_ver;
    fresh.src      = ev_src;
    fresh.region   = ev_region;
    fresh.bunch    = ev_bunch;
    fresh.bufn     = ev_buf;
    fresh.up_lat   = prev_lat;
    fresh.here_lat = lat_clamped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (load_new) begin
      cur <= fresh;
    end else if (load_held) begin
      cur <= held;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held     <= '0;
      held_vld <= 1'b0;
    end else if (hold_new) begin
      held     <= fresh;
      held_vld <= 1'b1;
    end else if (load_held) begin
      held_vld <= 1'b0;
    end
  end

endmodule

// File: rtl/frag_size_cnt.sv
module frag_size_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc && (cnt != TOP)) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/frag_ctrl.sv
module frag_ctrl
  import frag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  desc_t             cur,
  input  logic              held_vld,
  input  logic [SIZE_W-1:0] size_cnt,
  input  logic [ERR_W-1:0]  err_in,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_ctl,
  output logic              load_new,
  output logic              load_held,
  output logic              hold_new,
  output logic              cnt_clr,
  output logic              cnt_inc
);

  phase_t             ph_q, ph_d;
  logic               ovl_q;
  logic [ERR_W:0]     trl_err_q;
  logic               out_hs;
  logic               in_hs;
  logic               busy;
  logic               start;
  logic [WORD_W-1:0]  hdr_word;
  logic [WORD_W-1:0]  stamp_word;
  logic [WORD_W-1:0]  trl_word;

  assign hdr_word   = {cur.ver, cur.src, cur.region, cur.bunch, cur.bufn};
  assign stamp_word = {cur.up_lat, cur.here_lat};
  assign trl_word   = {size_cnt, trl_err_q};

  assign busy   = (ph_q == PH_HDR) || (ph_q == PH_STAMP) || (ph_q == PH_DATA);
  assign out_hs = out_valid && out_ready;
  assign in_hs  = in_valid && in_ready;

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = '0;
    out_ctl   = 1'b0;
    unique case (ph_q)
      PH_HDR: begin
        out_valid = 1'b1;
        out_data  = hdr_word;
        out_ctl   = 1'b1;
      end
      PH_STAMP: begin
        out_valid = 1'b1;
        out_data  = stamp_word;
        out_ctl   = 1'b1;
      end
      PH_DATA: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_data;
      end
      PH_TRL: begin
        out_valid = 1'b1;
        out_data  = trl_word;
        out_ctl   = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    ph_d      = ph_q;
    load_new  = 1'b0;
    load_held = 1'b0;
    hold_new  = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (sof) begin
          load_new = 1'b1;
          ph_d     = PH_HDR;
        end
      end
      PH_HDR:   if (out_hs) ph_d = PH_STAMP;
      PH_STAMP: if (out_hs) ph_d = PH_DATA;
      PH_DATA:  if (in_hs && in_last) ph_d = PH_TRL;
      PH_TRL: begin
        if (out_hs) begin
          if (sof) begin
            load_new = 1'b1;
            ph_d     = PH_HDR;
          end else if (held_vld) begin
            load_held = 1'b1;
            ph_d      = PH_HDR;
          end else begin
            ph_d = PH_IDLE;
          end
        end else if (sof) begin
          hold_new = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  assign start   = load_new || load_held;
  assign cnt_clr = start;
  assign cnt_inc = in_hs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      ovl_q     <= 1'b0;
      trl_err_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (start) begin
        ovl_q <= 1'b0;
      end else if (sof && busy) begin
        ovl_q <= 1'b1;
      end
      if (in_hs && in_last) begin
        trl_err_q <= {ovl_q || sof, err_in};
      end
    end
  end

endmodule

// File: rtl/frag_stream_fmt.sv
module frag_stream_fmt
  import frag_pkg::*;
#(
  parameter int LAT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic [7:0]       ev_ver,
  input  logic [3:0]       ev_src,
  input  logic [3:0]       ev_region,
  input  logic [7:0]       ev_bunch,
  input  logic [7:0]       ev_buf,
  input  logic [15:0]      prev_lat,
  input  logic [LAT_W-1:0] lat_now,
  input  logic [14:0]      err_in,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_data,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  output logic             out_ctl
);

  desc_t             cur;
  logic              held_vld;
  logic              load_new;
  logic              load_held;
  logic              hold_new;
  logic              cnt_clr;
  logic              cnt_inc;
  logic [SIZE_W-1:0] size_cnt;

  frag_desc_cap #(.LAT_W(LAT_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_ver    (ev_ver),
    .ev_src    (ev_src),
    .ev_region (ev_region),
    .ev_bunch  (ev_bunch),
    .ev_buf    (ev_buf),
    .prev_lat  (prev_lat),
    .lat_now   (lat_now),
    .load_new  (load_new),
    .load_held (load_held),
    .hold_new  (hold_new),
    .cur       (cur),
    .held_vld  (held_vld)
  );

  frag_size_cnt #(.W(SIZE_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .cnt   (size_cnt)
  );

  frag_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sof       (sof),
    .cur       (cur),
    .held_vld  (held_vld),
    .size_cnt  (size_cnt),
    .err_in    (err_in),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_ctl   (out_ctl),
    .load_new  (load_new),
    .load_held (load_held),
    .hold_new  (hold_new),
    .cnt_clr   (cnt_clr),
    .cnt_inc   (cnt_inc)
  );

endmodule

// File: rtl/frag_stream_fmt_chk.sv
module frag_stream_fmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_data,
  input logic        in_last,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        out_ctl
);

  a_r7_cut_through: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> out_ready && (!in_valid || (out_valid && !out_ctl && out_data == in_data)));

  a_r12_no_input_on_framing: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ctl) |-> !in_ready);

  a_r8_framing_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ctl && !out_ready) |=> (out_valid && out_ctl && $stable(out_data)));

  a_r6_payload_is_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ctl) |-> (in_valid && out_data == in_data));

  a_r2_trailer_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> (out_valid && out_ctl));

endmodule

bind frag_stream_fmt frag_stream_fmt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_ctl   (out_ctl)
);

// File: tb/frag_stream_fmt_bench.sv
`timescale 1ns/100ps
module frag_stream_fmt_bench;

  localparam int LW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sof = 1'b0;
  logic [7:0]    ev_ver = '0;
  logic [3:0]    ev_src = '0;
  logic [3:0]    ev_region = '0;
  logic [7:0]    ev_bunch = '0;
  logic [7:0]    ev_buf = '0;
  logic [15:0]   prev_lat = '0;
  logic [LW-1:0] lat_now = '0;
  logic [14:0]   err_in = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [31:0]   in_data = '0;
  logic          in_last = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [31:0]   out_data;
  logic          out_ctl;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int rdy_mode = 0;
  bit done = 1'b0;

  logic [32:0] exp_q[$];
  string       tag_q[$];

  frag_stream_fmt #(.LAT_W(LW)) u_frag_stream_fmt (
    .clk(clk), .rst_n(rst_n), .sof(sof), .ev_ver(ev_ver), .ev_src(ev_src),
    .ev_region(ev_region), .ev_bunch(ev_bunch), .ev_buf(ev_buf),
    .prev_lat(prev_lat), .lat_now(lat_now), .err_in(err_in),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ctl(out_ctl)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [32:0] act,
                     input logic [32:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] clamp(input logic [LW-1:0] x);
    return (x > LW'(20'h0FFFF)) ? 16'hFFFF : x[15:0];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 2) == 0;
      2: out_ready = (cyc % 3) == 0;
      default: ;
    endcase
  end

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 extra word", {out_ctl, out_data}, 33'h0);
      end else begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({out_ctl, out_data} === e, t, {out_ctl, out_data}, e);
      end
    end
  end

  task automatic start_event(input int ev, input logic [LW-1:0] lat,
                             input bit expect_out);
    logic [7:0] v  = 8'(8'h10 + ev);
    logic [3:0] s  = 4'(ev * 3);
    logic [3:0] r  = 4'(ev + 5);
    logic [7:0] b  = 8'(ev * 7 + 1);
    logic [7:0] bf = 8'(255 - ev);
    logic [15:0] pl = 16'(16'h0A00 + ev);
    @(posedge clk); #1;
    sof = 1'b1; ev_ver = v; ev_src = s; ev_region = r; ev_bunch = b;
    ev_buf = bf; prev_lat = pl; lat_now = lat;
    if (expect_out) begin
      exp_q.push_back({1'b1, v, s, r, b, bf});
      tag_q.push_back("R3 R6 header");
      exp_q.push_back({1'b1, pl, clamp(lat)});
      tag_q.push_back("R4 R6 stamp");
    end
    @(posedge clk); #1;
    sof = 1'b0;
    ev_ver = 8'hEE;
  endtask

  task automatic send_words(input int ev, input int n, input bit gaps,
                            input logic [14:0] err, input int ovl_at);
    for (int i = 0; i < n; i++) begin
      bit hs;
      logic [31:0] w = 32'hD000_0000 | (32'(ev) << 20) | 32'(i);
      if (gaps && (i % 2 == 1)) begin
        in_valid = 1'b0;
        @(posedge clk); #1;
      end
      in_valid = 1'b1; in_data = w; in_last = (i == n - 1);
      err_in = (i == n - 1) ? err : 15'h7FFF;
      if (i == ovl_at) begin
        sof = 1'b1; ev_ver = 8'h99; lat_now = 20'h00333;
      end
      exp_q.push_back({1'b0, w});
      tag_q.push_back((rdy_mode == 0) ? "R2 R6 payload" : "R8 R6 payload");
      hs = 1'b0;
      while (!hs) begin
        @(negedge clk);
        if (in_ready && n < 100)
          chk(out_valid && !out_ctl && out_data == w, "R7 same-cycle pass",
              {out_ctl, out_data}, {1'b0, w});
        hs = in_valid && in_ready;
        @(posedge clk); #1;
        sof = 1'b0;
      end
    end
    in_valid = 1'b0; in_last = 1'b0;
    exp_q.push_back({1'b1, (n > 65535) ? 16'hFFFF : 16'(n),
                     (ovl_at >= 0) ? 1'b1 : 1'b0, err});
    tag_q.push_back((n > 65535) ? "R11 trailer" :
                    (ovl_at >= 0) ? "R9 trailer" : "R5 R6 trailer");
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    @(posedge clk); #1;
  endtask

  initial begin
    logic [LW-1:0] lats[4];
    lats[0] = 20'h00123; lats[1] = 20'h0FFFF; lats[2] = 20'h10000; lats[3] = 20'hFFFFF;

    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 out_valid in reset", {32'h0, out_valid}, 33'h0);
    chk(in_ready == 1'b0, "R1 in_ready in reset", {32'h0, in_ready}, 33'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b0, "R1 idle after reset",
        {31'h0, out_valid, in_ready}, 33'h0);

    // sweep: word count x ready pattern x input gaps (R2 R3 R4 R5 R6 R7 R8)
    for (int n = 1; n <= 5; n++) begin
      for (int m = 0; m < 3; m++) begin
        for (int g = 0; g < 2; g++) begin
          int ev = n * 6 + m * 2 + g;
          rdy_mode = m;
          start_event(ev, lats[ev % 4], 1'b1);
          send_words(ev, n, g[0], 15'(ev * 37), -1);
          drain();
        end
      end
    end

    // R9: start pulse mid payload, and in the same cycle as the last word
    rdy_mode = 1;
    start_event(40, lats[0], 1'b1);
    send_words(40, 4, 1'b0, 15'h0011, 1);
    drain();
    start_event(41, lats[1], 1'b1);
    send_words(41, 3, 1'b1, 15'h0022, 2);
    drain();
    repeat (6) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R9 dropped start emits nothing",
          {32'h0, out_valid}, 33'h0);
    end
    @(posedge clk); #1;

    // R10: start pulse while the trailer is stalled
    rdy_mode = 3;
    out_ready = 1'b1;
    start_event(50, lats[2], 1'b1);
    send_words(50, 2, 1'b0, 15'h0050, -1);
    out_ready = 1'b0;
    start_event(51, lats[3], 1'b1);
    repeat (2) @(posedge clk);
    #1;
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid && out_ctl && out_data[31:16] == 16'd2, "R10 trailer still pending",
        {out_ctl, out_data}, {1'b1, 16'd2, 1'b0, 15'h0050});
    @(posedge clk); #1;
    @(negedge clk);
    chk(out_valid && out_ctl && out_data[31:24] == 8'(8'h10 + 51),
        "R10 header next cycle", {out_ctl, out_data}, {1'b1, 8'(8'h10 + 51), 24'h0});
    @(posedge clk); #1;
    send_words(51, 3, 1'b0, 15'h0051, -1);
    drain();

    // R12: header stalled, input offered, input must not be accepted
    out_ready = 1'b0;
    start_event(52, lats[0], 1'b1);
    in_valid = 1'b1; in_data = 32'hBAD0_0000; in_last = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R12 in_ready low with header pending",
          {32'h0, in_ready}, 33'h0);
      chk(out_valid && out_ctl && out_data[31:24] == 8'(8'h10 + 52),
          "R8 header held", {out_ctl, out_data}, {1'b1, 8'(8'h10 + 52), 24'h0});
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
    out_ready = 1'b1;
    send_words(52, 1, 1'b0, 15'h0052, -1);
    drain();

    // R11: count saturation with a long event
    rdy_mode = 0;
    start_event(60, lats[1], 1'b1);
    send_words(60, 65537, 1'b0, 15'h0060, -1);
    drain();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule